// File: doc/BRIEF.md
# Bit-Slice Transpose Input Buffer

This buffer feeds a distributed-arithmetic inverse transform stage. The upstream dequantizer delivers eight 16-bit coefficients of one block, one per write strobe, starting with coefficient 0. Once all eight have arrived, the buffer raises a ready flag. It then returns the block as 4-bit slices taken across the stored words. Each slice gathers one bit position from a group of four coefficients, and the downstream stage uses that nibble directly as a ROM address.

A drain walks the bit positions from the least significant bit to the most significant. At each position it emits two slices: first the slice for coefficients 0 to 3, then the slice for coefficients 4 to 7. A block therefore takes 32 reads. After the last read the flag drops, and the buffer accepts the next block. The fill and drain phases never overlap. Writes are discarded while the flag is high, and reads are discarded while it is low.

Top module: `slice_xpose_buf`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives `blockReady` to 0 and `sliceOut` to 0. It also clears the fill and drain positions, so the next accepted write is stored as coefficient 0.
- R2: While `blockReady` is 0, each cycle with `wrEn` high stores `wrData` as the next coefficient. The first write after reset or after a completed drain is coefficient 0, and each later write takes the next index up to 7.
- R3: `blockReady` is 0 during the fill. It reads 1 in the cycle after the rising edge that accepts the eighth write.
- R4: While `blockReady` is 1, `wrEn` has no effect. The stored coefficients and the read results of the pending drain are unchanged.
- R5: Bit j of a slice for group g and bit position k equals bit k of coefficient 4·g + j, for j = 0..3. Group 0 covers coefficients 0–3 and group 1 covers coefficients 4–7.
- R6: Read number r of a block (r = 0..31) returns bit position k = r / 2 and group g = r mod 2. The slice for group 0 comes before the slice for group 1 at each bit position, and bit positions run from 0 to 15.
- R7: `sliceOut` is registered. It shows the slice of a read in the cycle after the edge that accepts `rdEn`, and it holds its value through cycles with no accepted read.
- R8: `blockReady` reads 0 in the cycle after the edge that accepts the 32nd read. While `blockReady` is 0, `rdEn` has no effect and `sliceOut` holds.
- R9: A reset during a fill or a drain abandons that block. The next eight writes form a complete new block, and it drains correctly from read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for one coefficient |
| wrData | input | 16 | Coefficient being written |
| rdEn | input | 1 | Read strobe for one slice |
| sliceOut | output | 4 | Registered 4-bit bit slice |
| blockReady | output | 1 | High from a completed fill until the drain completes |

## Verification
The embedded properties assume that a strobe arriving in the wrong phase is simply dropped. A rise of the flag must therefore be traced to a write in the previous cycle, and a fall outside reset to a read. They also assume that the control never issues a store and a slice fetch in the same cycle. The stimulus keeps within these assumptions without constraining the inputs: it deliberately raises `wrEn` during a drain and `rdEn` during a fill, and it checks at the ports that both are ignored. It also inserts idle gaps between reads and applies reset in the middle of both phases.

// File: rtl/xpose_pkg.sv
package xpose_pkg;
  parameter int unsigned XP_WORD_W  = 16;
  parameter int unsigned XP_WORDS   = 8;
  parameter int unsigned XP_SLICE_W = 4;

  localparam int unsigned XP_GROUPS = XP_WORDS / XP_SLICE_W;
  localparam int unsigned XP_READS  = XP_WORD_W * XP_GROUPS;
  localparam int unsigned XP_WIDX_W = (XP_WORDS  > 1) ? $clog2(XP_WORDS)  : 1;
  localparam int unsigned XP_BIDX_W = (XP_WORD_W > 1) ? $clog2(XP_WORD_W) : 1;
  localparam int unsigned XP_GIDX_W = (XP_GROUPS > 1) ? $clog2(XP_GROUPS) : 1;
  localparam int unsigned XP_RCNT_W = (XP_READS  > 1) ? $clog2(XP_READS)  : 1;

  typedef struct packed {
    logic                 wrStrobe;
    logic [XP_WIDX_W-1:0] wrIdx;
    logic                 rdStrobe;
    logic [XP_BIDX_W-1:0] bitIdx;
    logic [XP_GIDX_W-1:0] grpIdx;
  } xpose_ctl_t;
endpackage

// File: rtl/xpose_ctrl.sv
module xpose_ctrl
  import xpose_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       rdEn,
  output xpose_ctl_t ctl,
  output logic       blockReady
);
  localparam int unsigned LAST_WR = XP_WORDS - 1;
  localparam int unsigned LAST_RD = XP_READS - 1;

  logic [XP_WIDX_W-1:0] wrCnt;
  logic [XP_RCNT_W-1:0] rdCnt;
  logic                 readyQ;
  logic                 wrTake;
  logic                 rdTake;

  assign wrTake = wrEn && !readyQ;
  assign rdTake = rdEn && readyQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrCnt  <= '0;
      rdCnt  <= '0;
      readyQ <= 1'b0;
    end else begin
      if (wrTake) begin
        if (wrCnt == XP_WIDX_W'(LAST_WR)) begin
          wrCnt  <= '0;
          readyQ <= 1'b1;
        end else begin
          wrCnt <= wrCnt + 1'b1;
        end
      end
      if (rdTake) begin
        if (rdCnt == XP_RCNT_W'(LAST_RD)) begin
          rdCnt  <= '0;
          readyQ <= 1'b0;
        end else begin
          rdCnt <= rdCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.wrStrobe = wrTake;
    ctl.wrIdx    = wrCnt;
    ctl.rdStrobe = rdTake;
    ctl.bitIdx   = XP_BIDX_W'(rdCnt / XP_RCNT_W'(XP_GROUPS));
    ctl.grpIdx   = XP_GIDX_W'(rdCnt % XP_RCNT_W'(XP_GROUPS));
  end

  assign blockReady = readyQ;

  // R3: the flag only rises as the result of a write in the previous cycle
  p_ready_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(readyQ) |-> $past(wrEn));

  // R8: outside reset the flag only falls as the result of a read
  p_ready_fall_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(readyQ) && !$past(rst)) |-> $past(rdEn));

  // R2: a full block always has its fill position parked at coefficient 0
  p_fill_parked_r2: assert property (@(posedge clk) disable iff (rst)
    readyQ |-> (wrCnt == '0));

  // R6: while filling, the drain position is parked at read 0
  p_drain_parked_r6: assert property (@(posedge clk) disable iff (rst)
    !readyQ |-> (rdCnt == '0));
endmodule

// File: rtl/xpose_dpath.sv
module xpose_dpath
  import xpose_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  xpose_ctl_t            ctl,
  input  logic [XP_WORD_W-1:0]  wrData,
  output logic [XP_SLICE_W-1:0] sliceOut
);
  logic [XP_WORD_W-1:0]  coefMem [XP_WORDS];
  logic [XP_SLICE_W-1:0] sliceNxt;

  always_ff @(posedge clk) begin
    if (ctl.wrStrobe) coefMem[ctl.wrIdx] <= wrData;
  end

  for (genvar j = 0; j < XP_SLICE_W; j++) begin : g_slice
    always_comb begin
      sliceNxt[j] = coefMem[XP_WIDX_W'(int'(ctl.grpIdx) * XP_SLICE_W + j)][ctl.bitIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               sliceOut <= '0;
    else if (ctl.rdStrobe) sliceOut <= sliceNxt;
  end

  // R4: a store and a slice fetch never share a cycle
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !(ctl.wrStrobe && ctl.rdStrobe));
endmodule

// File: rtl/slice_xpose_buf.sv
module slice_xpose_buf
  import xpose_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [XP_WORD_W-1:0]  wrData,
  input  logic                  rdEn,
  output logic [XP_SLICE_W-1:0] sliceOut,
  output logic                  blockReady
);
  xpose_ctl_t ctl;

  xpose_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .ctl        (ctl),
    .blockReady (blockReady)
  );

  xpose_dpath dpath_i (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .wrData   (wrData),
    .sliceOut (sliceOut)
  );
endmodule

// File: tb/slice_xpose_buf_tb.sv
module slice_xpose_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [3:0]  sliceOut;
  logic        blockReady;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] blk [8];

  always #2 clk = ~clk;

  slice_xpose_buf dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .sliceOut(sliceOut), .blockReady(blockReady)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expSlice(input int r);
    logic [3:0] s;
    int k = r / 2;
    int g = r % 2;
    for (int j = 0; j < 4; j++) s[j] = blk[4*g + j][k];
    return s;
  endfunction

  task automatic doReset();
    rst = 1'b1; wrEn = 1'b0; rdEn = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic writeOne(input logic [15:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic fillBlock(input int seed);
    for (int n = 0; n < 8; n++) begin
      blk[n] = 16'((seed * 16'h9e37) ^ (n * 16'h1f31) ^ (seed << n));
      chk("R3 ready low during fill", {15'd0, blockReady}, 16'd0);
      writeOne(blk[n]);
    end
    chk("R3 ready after eighth write", {15'd0, blockReady}, 16'd1);
  endtask

  task automatic drainBlock(input bit gaps);
    for (int r = 0; r < 32; r++) begin
      rdEn = 1'b1;
      @(negedge clk);
      rdEn = 1'b0;
      chk("R5 R6 R7 slice", {12'd0, sliceOut}, {12'd0, expSlice(r)});
      if (gaps && (r % 5 == 2)) begin
        @(negedge clk);
        chk("R7 hold without read", {12'd0, sliceOut}, {12'd0, expSlice(r)});
      end
      if (r < 31) chk("R8 ready during drain", {15'd0, blockReady}, 16'd1);
    end
    chk("R8 ready falls after last read", {15'd0, blockReady}, 16'd0);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    chk("R8 read while empty ignored", {12'd0, sliceOut}, {12'd0, expSlice(31)});
  endtask

  initial begin
    doReset();
    chk("R1 ready after reset", {15'd0, blockReady}, 16'd0);
    chk("R1 slice after reset", {12'd0, sliceOut}, 16'd0);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    chk("R8 read before fill ignored", {12'd0, sliceOut}, 16'd0);

    // several data patterns, including walking ones and all ones
    for (int b = 1; b <= 6; b++) begin
      fillBlock(b);
      if (b == 2) for (int n = 0; n < 8; n++) blk[n] = 16'h0001 << (2*n + 1);
      if (b == 3) for (int n = 0; n < 8; n++) blk[n] = 16'hffff;
      if (b == 2 || b == 3) begin
        // rewrite block in place: previous fill already accepted, so redo
        doReset();
        for (int n = 0; n < 8; n++) writeOne(blk[n]);
        chk("R2 R3 ready after fixed pattern", {15'd0, blockReady}, 16'd1);
      end
      // R4: writes while full are ignored
      for (int n = 0; n < 3; n++) writeOne(~blk[n]);
      chk("R4 ready stays high", {15'd0, blockReady}, 16'd1);
      drainBlock(b % 2 == 0);
    end

    // R9: reset mid-fill
    fillBlock(40);
    drainBlock(1'b0);
    for (int n = 0; n < 3; n++) writeOne(16'hdead);
    doReset();
    chk("R1 ready after reset mid-fill", {15'd0, blockReady}, 16'd0);
    fillBlock(77);
    drainBlock(1'b0);

    // R9: reset mid-drain
    fillBlock(91);
    for (int r = 0; r < 11; r++) begin
      rdEn = 1'b1; @(negedge clk); rdEn = 1'b0;
    end
    doReset();
    chk("R9 ready low after reset mid-drain", {15'd0, blockReady}, 16'd0);
    chk("R1 slice cleared mid-drain", {12'd0, sliceOut}, 16'd0);
    fillBlock(123);
    drainBlock(1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule